// File: doc/BRIEF.md
# Trap Priority and Vector Unit

This block sits beside a processor pipeline and turns trap requests into control transfers. Six request classes feed it: a reset trap, an asynchronous error, an execute-unit exception, a load/store exception, a fetch exception, and software traps or interrupts raised by the trap logic itself. Each cycle it picks one winning class. It then flushes the pipeline, pushes the interrupted PC, next PC and processor state word onto a trap stack indexed by the current trap level, and steers fetch to a handler address. That address is built from a programmable base register, the winning trap type and whether the core was already inside a handler. Each handler owns a 32-byte slot, which holds eight instructions.

Handler exits use two strobes. DONE resumes at the saved next PC. RETRY re-executes the saved PC. Both restore the saved state word and drop the trap level by one. The stack has a fixed number of levels. A trap that arrives when every level is in use does not push. It raises a sticky error-state flag instead.

No interface of this block carries a data stream. Every pin is a plain level or single-cycle pulse with no back-pressure, because trap entry and return are never stalled. All outputs are registered and appear one clock after the request is sampled.

Top module: `trap_unit`

## Requirements
- R1: When several classes request in the same cycle, the winner is the lowest class index. The indices are: reset trap 0, asynchronous error 1, execute exception 2, load/store exception 3, fetch exception 4, software trap/interrupt 5.
- R2: On the clock edge that samples a winning trap below the maximum level, the unit does three things in the following cycle. It pulses `flush_o`. It pulses `redir_valid_o`. It drives `redir_pc_o` = {base[63:15], (level!=0), type[8:0], 5'b00000}. Here "level" is the trap level before entry.
- R3: `lsu_flush_o` pulses with `flush_o` only when the winning class is 2, 3 or 4. Classes 0, 1 and 5 flush the pipeline without it.
- R4: Requests of classes 0, 1 and 5 are held pending until they win, together with their latest type. A request of class 2, 3 or 4 that loses arbitration is dropped.
- R5: Every trap entry below the maximum level pushes PC, next PC and state, and raises `tl_o` by one. `tl_o` never exceeds 6.
- R6: A trap taken when `tl_o` is 6 still pulses `flush_o`. It pushes nothing, gives no redirect, and leaves `tl_o` at 6. It sets `error_state_o`, which stays high until `rst_n` is asserted.
- R7: At a nonzero level, DONE redirects to the saved next PC and RETRY redirects to the saved PC. Either one also pulses `restore_valid_o` with the saved state word and lowers `tl_o` by one. If both strobes arrive together, DONE takes effect.
- R8: DONE and RETRY have no effect at level 0, and none in a cycle where a trap is taken.
- R9: A class 0 entry saves zero for PC, next PC and state, so a later return from it redirects to 0 and restores 0.
- R10: A base write keeps only bits [63:15], clearing bits [14:0]. It affects traps sampled on later edges, not a trap sampled on the same edge.
- R11: After reset, every output is 0 and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 6 | Per-class trap request, bit index = class |
| trap_type_i | input | 6x9 | Per-class trap type |
| cur_pc_i | input | 64 | PC of the interrupted instruction |
| cur_npc_i | input | 64 | Next PC of the interrupted instruction |
| cur_state_i | input | 8 | Processor state word to save |
| done_i | input | 1 | Handler exit, resume after the trapped instruction |
| retry_i | input | 1 | Handler exit, re-execute the trapped instruction |
| tba_wr_i | input | 1 | Load the trap base register |
| tba_wdata_i | input | 64 | New trap base value |
| flush_o | output | 1 | Pipeline flush pulse on trap entry |
| lsu_flush_o | output | 1 | Load/store flush pulse for synchronous exceptions |
| redir_valid_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | 64 | Redirect target |
| restore_valid_o | output | 1 | Saved state is being restored |
| restore_state_o | output | 8 | Restored state word |
| tl_o | output | 3 | Current trap level |
| error_state_o | output | 1 | Sticky trap-stack overflow flag |

## Verification
The bench fires all six classes at once, then checks that the three held classes drain on consecutive cycles in order and that the synchronous losers vanish. A unit that forgot pending requests would lose the error and interrupt traps. A unit that latched everything would run extra handlers. Nested entry checks the level bit in the vector and the next-free stack slot. Mixing DONE and RETRY across levels exposes a swapped PC/next-PC restore or an off-by-one stack read. The remaining corners are these:
- Filling the stack and taking one more trap catches overwriting or level wrap.
- A return at level 0 catches a level that drops below zero.
- A return in the same cycle as a trap catches a unit that lets the return win.
- A base write in the same cycle as a trap catches a unit that uses the new base too early.

// File: rtl/trapu_pkg.sv
package trapu_pkg;
  localparam int NCLS      = 6;
  localparam int TTW       = 9;
  localparam int SLOT_BITS = 5;   // eight 4-byte instructions per handler
  localparam int CIW       = $clog2(NCLS);

  typedef enum logic [CIW-1:0] {
    CL_RESET = 3'd0,
    CL_AERR  = 3'd1,
    CL_EXEC  = 3'd2,
    CL_LDST  = 3'd3,
    CL_FETCH = 3'd4,
    CL_SOFT  = 3'd5
  } trap_class_e;

  // classes that arrive independent of the pipeline and must be held
  localparam logic [NCLS-1:0] HELD_CLASSES = 6'b100011;
  // synchronous exceptions that also drain the load/store side
  localparam logic [NCLS-1:0] LSU_CLASSES  = 6'b011100;
  // classes whose context is not preserved on entry
  localparam logic [NCLS-1:0] NOSAVE_CLASSES = 6'b000001;
endpackage

// File: rtl/trapu_arbiter.sv
module trapu_arbiter
  import trapu_pkg::*;
#(
  parameter logic [NCLS-1:0] HOLD_MASK = HELD_CLASSES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCLS-1:0]           req_i,
  input  logic [NCLS-1:0][TTW-1:0]  type_i,
  output logic                      win_valid_o,
  output logic [CIW-1:0]            win_idx_o,
  output logic [TTW-1:0]            win_type_o
);
  logic [NCLS-1:0]          eff_req;
  logic [NCLS-1:0][TTW-1:0] eff_type;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    if (HOLD_MASK[g]) begin : g_held
      logic           pend_q;
      logic [TTW-1:0] typ_q;
      logic           taken;
      assign taken = win_valid_o && (win_idx_o == CIW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          typ_q  <= '0;
        end else begin
          pend_q <= (pend_q | req_i[g]) & ~taken;
          if (req_i[g]) typ_q <= type_i[g];
        end
      end
      assign eff_req[g]  = req_i[g] | pend_q;
      assign eff_type[g] = req_i[g] ? type_i[g] : typ_q;
    end else begin : g_live
      assign eff_req[g]  = req_i[g];
      assign eff_type[g] = type_i[g];
    end
  end

  always_comb begin
    win_idx_o = '0;
    for (int k = NCLS - 1; k >= 0; k--) begin
      if (eff_req[k]) win_idx_o = CIW'(k);
    end
  end

  assign win_valid_o = |eff_req;
  assign win_type_o  = eff_type[win_idx_o];
endmodule

// File: rtl/trapu_stack.sv
module trapu_stack #(
  parameter int DEPTH = 6,
  parameter int PCW   = 64,
  parameter int SW    = 8,
  parameter int IW    = 3
) (
  input  logic           clk,
  input  logic           push_i,
  input  logic [IW-1:0]  wr_idx_i,
  input  logic [PCW-1:0] wr_pc_i,
  input  logic [PCW-1:0] wr_npc_i,
  input  logic [SW-1:0]  wr_state_i,
  input  logic [IW-1:0]  rd_idx_i,
  output logic [PCW-1:0] rd_pc_o,
  output logic [PCW-1:0] rd_npc_o,
  output logic [SW-1:0]  rd_state_o
);
  logic [PCW-1:0] pc_mem    [DEPTH];
  logic [PCW-1:0] npc_mem   [DEPTH];
  logic [SW-1:0]  state_mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push_i && (wr_idx_i == IW'(e))) begin
        pc_mem[e]    <= wr_pc_i;
        npc_mem[e]   <= wr_npc_i;
        state_mem[e] <= wr_state_i;
      end
    end
  end

  always_comb begin
    rd_pc_o    = '0;
    rd_npc_o   = '0;
    rd_state_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx_i == IW'(e)) begin
        rd_pc_o    = pc_mem[e];
        rd_npc_o   = npc_mem[e];
        rd_state_o = state_mem[e];
      end
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trapu_pkg::*;
#(
  parameter int PCW    = 64,
  parameter int SW     = 8,
  parameter int MAX_TL = 6,
  localparam int TLW   = $clog2(MAX_TL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCLS-1:0]           trap_req_i,
  input  logic [NCLS-1:0][TTW-1:0]  trap_type_i,
  input  logic [PCW-1:0]            cur_pc_i,
  input  logic [PCW-1:0]            cur_npc_i,
  input  logic [SW-1:0]             cur_state_i,
  input  logic                      done_i,
  input  logic                      retry_i,
  input  logic                      tba_wr_i,
  input  logic [PCW-1:0]            tba_wdata_i,
  output logic                      flush_o,
  output logic                      lsu_flush_o,
  output logic                      redir_valid_o,
  output logic [PCW-1:0]            redir_pc_o,
  output logic                      restore_valid_o,
  output logic [SW-1:0]             restore_state_o,
  output logic [TLW-1:0]            tl_o,
  output logic                      error_state_o
);
  localparam int TBA_LSB = TTW + 1 + SLOT_BITS;

  logic                 win_valid;
  logic [CIW-1:0]       win_idx;
  logic [TTW-1:0]       win_type;
  logic [TLW-1:0]       tl_q;
  logic [PCW-1:0]       tba_q;
  logic                 at_max;
  logic                 push;
  logic                 ret_req;
  logic                 nosave;
  logic [PCW-1:0]       vec_addr;
  logic [PCW-1:0]       sv_pc, sv_npc;
  logic [SW-1:0]        sv_state;
  logic [PCW-1:0]       rd_pc, rd_npc;
  logic [SW-1:0]        rd_state;

  trapu_arbiter #(.HOLD_MASK(HELD_CLASSES)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (trap_req_i),
    .type_i      (trap_type_i),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_type_o  (win_type)
  );

  assign at_max   = (tl_q >= TLW'(MAX_TL));
  assign push     = win_valid && !at_max;
  assign ret_req  = !win_valid && (done_i || retry_i) && (tl_q != '0);
  assign nosave   = NOSAVE_CLASSES[win_idx];
  assign sv_pc    = nosave ? '0 : cur_pc_i;
  assign sv_npc   = nosave ? '0 : cur_npc_i;
  assign sv_state = nosave ? '0 : cur_state_i;
  assign vec_addr = {tba_q[PCW-1:TBA_LSB], (tl_q != '0), win_type, SLOT_BITS'(0)};

  trapu_stack #(.DEPTH(MAX_TL), .PCW(PCW), .SW(SW), .IW(TLW)) u_stk (
    .clk        (clk),
    .push_i     (push),
    .wr_idx_i   (tl_q),
    .wr_pc_i    (sv_pc),
    .wr_npc_i   (sv_npc),
    .wr_state_i (sv_state),
    .rd_idx_i   (tl_q - 1'b1),
    .rd_pc_o    (rd_pc),
    .rd_npc_o   (rd_npc),
    .rd_state_o (rd_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_q            <= '0;
      tba_q           <= '0;
      flush_o         <= 1'b0;
      lsu_flush_o     <= 1'b0;
      redir_valid_o   <= 1'b0;
      redir_pc_o      <= '0;
      restore_valid_o <= 1'b0;
      restore_state_o <= '0;
      error_state_o   <= 1'b0;
    end else begin
      flush_o         <= 1'b0;
      lsu_flush_o     <= 1'b0;
      redir_valid_o   <= 1'b0;
      restore_valid_o <= 1'b0;
      if (tba_wr_i) tba_q <= {tba_wdata_i[PCW-1:TBA_LSB], TBA_LSB'(0)};
      if (win_valid) begin
        flush_o     <= 1'b1;
        lsu_flush_o <= LSU_CLASSES[win_idx];
        if (push) begin
          tl_q          <= tl_q + 1'b1;
          redir_valid_o <= 1'b1;
          redir_pc_o    <= vec_addr;
        end else begin
          error_state_o <= 1'b1;
        end
      end else if (ret_req) begin
        tl_q            <= tl_q - 1'b1;
        redir_valid_o   <= 1'b1;
        redir_pc_o      <= done_i ? rd_npc : rd_pc;
        restore_valid_o <= 1'b1;
        restore_state_o <= rd_state;
      end
    end
  end

  assign tl_o = tl_q;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int PCW    = 64,
  parameter int SW     = 8,
  parameter int MAX_TL = 6,
  parameter int TLW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush_o,
  input logic           lsu_flush_o,
  input logic           redir_valid_o,
  input logic [PCW-1:0] redir_pc_o,
  input logic           restore_valid_o,
  input logic [TLW-1:0] tl_o,
  input logic           error_state_o
);
  p_tl_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tl_o <= TLW'(MAX_TL));

  p_tl_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && redir_valid_o) |-> (tl_o == $past(tl_o) + 1'b1));

  p_ret_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid_o |-> (tl_o + 1'b1 == $past(tl_o)));

  p_lsu_within_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_flush_o |-> flush_o);

  p_slot_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && redir_valid_o) |-> (redir_pc_o[4:0] == 5'd0));

  p_full_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && !redir_valid_o) |-> (error_state_o && tl_o == TLW'(MAX_TL)));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    error_state_o |=> error_state_o);

  p_trap_over_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid_o |-> (!flush_o && redir_valid_o));

  p_redir_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |-> (flush_o || restore_valid_o));
endmodule

bind trap_unit trap_unit_chk #(.PCW(PCW), .SW(SW), .MAX_TL(MAX_TL), .TLW(TLW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush_o         (flush_o),
  .lsu_flush_o     (lsu_flush_o),
  .redir_valid_o   (redir_valid_o),
  .redir_pc_o      (redir_pc_o),
  .restore_valid_o (restore_valid_o),
  .tl_o            (tl_o),
  .error_state_o   (error_state_o)
);

// File: tb/trap_unit_tb_top.sv
module trap_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [5:0]       trap_req = '0;
  logic [5:0][8:0]  trap_type = '0;
  logic [63:0]      cur_pc = '0, cur_npc = '0;
  logic [7:0]       cur_state = '0;
  logic             done = 1'b0, retry = 1'b0, tba_wr = 1'b0;
  logic [63:0]      tba_wdata = '0;
  logic             flush, lsu_flush, redir_valid, restore_valid, err;
  logic [63:0]      redir_pc;
  logic [7:0]       restore_state;
  logic [2:0]       tl;

  int vecs = 0;
  int fails = 0;
  bit reported = 0;
  logic [63:0] base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_type_i(trap_type),
    .cur_pc_i(cur_pc), .cur_npc_i(cur_npc), .cur_state_i(cur_state),
    .done_i(done), .retry_i(retry), .tba_wr_i(tba_wr), .tba_wdata_i(tba_wdata),
    .flush_o(flush), .lsu_flush_o(lsu_flush), .redir_valid_o(redir_valid),
    .redir_pc_o(redir_pc), .restore_valid_o(restore_valid),
    .restore_state_o(restore_state), .tl_o(tl), .error_state_o(err)
  );

  function automatic logic [63:0] vec(input logic [2:0] lvl, input logic [8:0] t);
    return {base[63:15], (lvl != 3'd0), t, 5'b00000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    trap_req = '0; done = 1'b0; retry = 1'b0; tba_wr = 1'b0;
  endtask

  // one edge with the current inputs, then drop them and stand at the next negedge
  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic hard_reset();
    rst_n = 1'b0; clear_in(); base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic entry(input int cls, input logic [8:0] t, input logic [63:0] pc,
                       input logic [7:0] st);
    trap_req[cls] = 1'b1; trap_type[cls] = t;
    cur_pc = pc; cur_npc = pc + 64'd4; cur_state = st;
  endtask

  task automatic t_reset_state();
    hard_reset();
    chk("R11 flush", {63'd0, flush}, 64'd0);
    chk("R11 lsu_flush", {63'd0, lsu_flush}, 64'd0);
    chk("R11 redir_valid", {63'd0, redir_valid}, 64'd0);
    chk("R11 restore_valid", {63'd0, restore_valid}, 64'd0);
    chk("R11 tl", {61'd0, tl}, 64'd0);
    chk("R11 error", {63'd0, err}, 64'd0);
  endtask

  task automatic t_base_and_nesting();
    // R10: write with trap on the same edge uses the old (zero) base
    tba_wr = 1'b1; tba_wdata = 64'hFFFF_0000_1234_7FFF;
    entry(2, 9'h1A, 64'h100, 8'h11);
    step();
    chk("R10 same-edge base", redir_pc, {49'd0, 1'b0, 9'h1A, 5'd0});
    base = 64'hFFFF_0000_1234_0000;
    chk("R3 exec lsu_flush", {63'd0, lsu_flush}, 64'd1);
    chk("R5 tl after first", {61'd0, tl}, 64'd1);
    // R2: nested fetch exception sets the level bit
    entry(4, 9'h005, 64'h200, 8'h33);
    step();
    chk("R2 flush", {63'd0, flush}, 64'd1);
    chk("R2 nested vector", redir_pc, vec(3'd1, 9'h005));
    chk("R5 tl after second", {61'd0, tl}, 64'd2);
    // R7: RETRY then DONE
    retry = 1'b1; step();
    chk("R7 retry pc", redir_pc, 64'h200);
    chk("R7 retry state", {56'd0, restore_state}, 64'h33);
    chk("R7 retry no flush", {63'd0, flush}, 64'd0);
    done = 1'b1; step();
    chk("R7 done npc", redir_pc, 64'h104);
    chk("R7 done state", {56'd0, restore_state}, 64'h11);
    chk("R7 tl back to 0", {61'd0, tl}, 64'd0);
  endtask

  task automatic t_return_corners();
    done = 1'b1; step();
    chk("R8 return at level 0", {63'd0, redir_valid}, 64'd0);
    chk("R8 level stays 0", {61'd0, tl}, 64'd0);
    entry(5, 9'h060, 64'h300, 8'h44); done = 1'b1;
    step();
    chk("R8 trap beats return", {61'd0, tl}, 64'd1);
    chk("R8 no restore", {63'd0, restore_valid}, 64'd0);
    chk("R3 soft no lsu_flush", {63'd0, lsu_flush}, 64'd0);
    done = 1'b1; retry = 1'b1; step();
    chk("R7 done wins", redir_pc, 64'h304);
  endtask

  task automatic t_sync_priority();
    entry(2, 9'h010, 64'h400, 8'h01);
    entry(3, 9'h011, 64'h400, 8'h01);
    entry(4, 9'h012, 64'h400, 8'h01);
    step();
    chk("R1 exec over ldst/fetch", redir_pc, vec(3'd0, 9'h010));
    step();
    chk("R4 sync losers dropped", {63'd0, flush}, 64'd0);
    done = 1'b1; step();
    entry(3, 9'h011, 64'h400, 8'h01);
    entry(4, 9'h012, 64'h400, 8'h01);
    step();
    chk("R1 ldst over fetch", redir_pc, vec(3'd0, 9'h011));
    done = 1'b1; step();
  endtask

  task automatic t_async_drain();
    for (int c = 0; c < 6; c++) entry(c, 9'(c + 1), 64'h500, 8'h55);
    step();
    chk("R1 reset class first", redir_pc, vec(3'd0, 9'h001));
    chk("R3 reset no lsu_flush", {63'd0, lsu_flush}, 64'd0);
    @(negedge clk);
    chk("R4 held async error next", redir_pc, vec(3'd1, 9'h002));
    @(negedge clk);
    chk("R4 held soft trap next", redir_pc, vec(3'd2, 9'h006));
    chk("R5 tl 3", {61'd0, tl}, 64'd3);
    @(negedge clk);
    chk("R4 nothing left", {63'd0, flush}, 64'd0);
    retry = 1'b1; step();
    chk("R7 pop soft", redir_pc, 64'h500);
    retry = 1'b1; step();
    chk("R7 pop aerr", redir_pc, 64'h500);
    retry = 1'b1; step();
    chk("R9 reset entry pc zero", redir_pc, 64'd0);
    chk("R9 reset entry state zero", {56'd0, restore_state}, 64'd0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 6; i++) begin
      entry(2, 9'h020, 64'h600, 8'h66);
      step();
    end
    chk("R5 full level", {61'd0, tl}, 64'd6);
    entry(2, 9'h021, 64'h700, 8'h77);
    step();
    chk("R6 flush at full", {63'd0, flush}, 64'd1);
    chk("R6 no redirect", {63'd0, redir_valid}, 64'd0);
    chk("R6 error set", {63'd0, err}, 64'd1);
    chk("R6 level held", {61'd0, tl}, 64'd6);
    done = 1'b1; step();
    chk("R6 error sticky", {63'd0, err}, 64'd1);
    chk("R7 pop top keeps old entry", redir_pc, 64'h604);
    hard_reset();
    chk("R11 error cleared", {63'd0, err}, 64'd0);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset_state();
    t_base_and_nesting();
    t_return_corners();
    t_sync_priority();
    t_async_drain();
    t_overflow();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end
endmodule